// File: doc/BRIEF.md
# Programmable Memory Waveform Sequencer

This block drives the control lines of an external memory device from a small table of control words. It runs on a fast clock at four times the bus rate, so each fast clock is one quarter phase of a bus clock. Every table word covers one bus clock and gives each general-purpose line one level for the first half (quarter phases 1 and 2) and one for the second half (quarter phases 3 and 4). A word can run for one to four bus clocks before the sequencer moves on to the next table entry. A sequence begins at a start index and ends at the first word whose end flag is set.

One line is shared. A per-machine mode input sets its role. In output mode it is driven like the other lines. In wait mode it becomes a wait input: a word can let it freeze the whole sequence, and a word also chooses where read data is sampled. Software fills the table through a valid/ready write port. `wr_ready` is high only while the sequencer is idle. A write is taken on any clock edge where `wr_valid` and `wr_ready` are both high, so while a sequence runs the writer waits, holding its address and data.

Top module: `mwseq_top`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy`, `done` and `sample_stb` are 0, `gpl_out` is all zeros and `wr_ready` is 1.
- R2: When `start` is high on an idle edge, the word at `start_idx` is loaded and `busy` rises. The fast clock after that edge is quarter phase 1 of the word's first bus clock.
- R3: Word bit fields: [15] end flag, [14:13] repeat, [12] line 0 first-half level, [11:10] line 0 second-half code, and for line k (1..5) bit 2k-2 is its first-half level and bit 2k-1 its second-half level. `gpl_out[k]` follows these bits for lines 1, 2, 3 and 5, using the first-half bit in quarter phases 1-2 and the second-half bit in quarter phases 3-4.
- R4: Line 0 second-half code: 10 drives 0, 11 drives 1, and 00 or the reserved 01 drives `line0_dflt`.
- R5: A repeat value r runs the word for r+1 bus clocks (4(r+1) fast clocks).
- R6: After its last bus clock, a word without the end flag is followed by the word at the next index, wrapping from 63 to 0. A word with the end flag ends the sequence: `busy` falls and `done` is high for exactly one fast clock.
- R7: With `mode_wait`=0, line 4 is driven from bits 6 and 7 and `gpl4_oe`=1. With `mode_wait`=1, `gpl4_oe`=0 and `gpl_out[4]`=0.
- R8: With `mode_wait`=1 and bit 7 of the current word set, `wait_in` is synchronised through two flops. While the synchronised value is 1, all outputs hold their values and neither the quarter phase nor the repeat count advances, so the sequence lasts one extra fast clock per frozen clock.
- R9: `wait_in` has no effect when bit 7 of the word is 0 or when `mode_wait`=0.
- R10: With `mode_wait`=1, `read_op`=1 and bit 6 of the word set, `sample_stb` is high for one fast clock at the start of quarter phase 3 of each bus clock of that word.
- R11: With `mode_wait`=1, `read_op`=1 and bit 6 clear, `sample_stb` is high for one fast clock at the start of quarter phase 1 of the following bus clock, even after the sequence has ended. With `read_op`=0, or with `mode_wait`=0, it stays 0.
- R12: While `busy`, `wr_ready` is 0, writes are not taken and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four per bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Table write accepted this edge when high with wr_valid |
| wr_addr | input | 6 | Table write index |
| wr_data | input | 16 | Table word to store |
| start | input | 1 | Begin a sequence when idle |
| start_idx | input | 6 | First table index of the sequence |
| mode_wait | input | 1 | Shared line role: 0 output, 1 wait input |
| line0_dflt | input | 1 | Per-machine line 0 default level |
| read_op | input | 1 | Current access is a single or burst read |
| wait_in | input | 1 | External wait, active high |
| gpl_out | output | 6 | Control line levels, bit k is line k |
| gpl4_oe | output | 1 | Output enable of the shared line |
| sample_stb | output | 1 | Read data sample strobe |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-clock pulse at sequence end |

## Verification
The bench goes after the half-phase boundary: a design that switches at the wrong quarter shows the second-half level in phase 2 or the first-half level in phase 3. It also runs the reserved line 0 code with both default values, because a decoder that treats 01 as a drive code gives a fixed level. It checks the repeat count and the wrap from index 63 to 0, where an off-by-one gives sequences of the wrong length or the wrong follow-on word. A wait held for five clocks must stretch the run by exactly five clocks and keep the outputs still. Two things must leave the run length unchanged: a wait the word does not enable, and a start or write sent while a sequence runs. Both sample-point choices are checked, and a strobe one quarter off or missing would be caught.

// File: rtl/mwseq_pkg.sv
package mwseq_pkg;
  localparam int WORD_W  = 16;
  localparam int N_LINES = 6;
  localparam int PAIR_W  = 10;

  typedef struct packed {
    logic              last;
    logic [1:0]        rep;
    logic              l0_t1;
    logic [1:0]        l0_code;
    logic [PAIR_W-1:0] pair;
  } mw_word_t;

  localparam logic [1:0] L0_DFLT = 2'b00;
  localparam logic [1:0] L0_RSVD = 2'b01;
  localparam logic [1:0] L0_LOW  = 2'b10;
  localparam logic [1:0] L0_HIGH = 2'b11;

  localparam logic [1:0] QP_LAST = 2'd3;
endpackage

// File: rtl/mwseq_table.sv
module mwseq_table #(
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [mwseq_pkg::WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [mwseq_pkg::WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [mwseq_pkg::WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mwseq_sync.sv
module mwseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mwseq_ctrl.sv
module mwseq_ctrl
  import mwseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_idx,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              mode_wait,
  input  logic              read_op,
  input  logic              wait_s,
  output logic [ADDR_W-1:0] rd_addr,
  output mw_word_t          word,
  output logic              second_half,
  output logic              busy,
  output logic              done,
  output logic              frozen,
  output logic              sample_stb
);
  localparam logic [ADDR_W-1:0] IDX_ONE = 1;

  logic [ADDR_W-1:0] idx_q;
  mw_word_t          word_q;
  logic [1:0]        qp_q;
  logic [1:0]        rep_q;
  logic              busy_q, done_q, stb_q;
  logic              late_pt, bus_end;

  assign frozen  = busy_q & mode_wait & word_q.pair[7] & wait_s;
  assign rd_addr = busy_q ? idx_q + IDX_ONE : start_idx;
  assign late_pt = word_q.pair[6];
  assign bus_end = (qp_q == QP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
      qp_q   <= '0;
      rep_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      stb_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          idx_q  <= start_idx;
          word_q <= mw_word_t'(rd_word);
          qp_q   <= '0;
          rep_q  <= '0;
        end
      end else if (!frozen) begin
        if (mode_wait && read_op) begin
          if (qp_q == 2'd1 && late_pt)  stb_q <= 1'b1;
          if (bus_end && !late_pt)      stb_q <= 1'b1;
        end
        qp_q <= qp_q + 2'd1;
        if (bus_end) begin
          if (rep_q == word_q.rep) begin
            rep_q <= '0;
            if (word_q.last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q  <= idx_q + IDX_ONE;
              word_q <= mw_word_t'(rd_word);
            end
          end else begin
            rep_q <= rep_q + 2'd1;
          end
        end
      end
    end
  end

  assign word        = word_q;
  assign second_half = qp_q[1];
  assign busy        = busy_q;
  assign done        = done_q;
  assign sample_stb  = stb_q;
endmodule

// File: rtl/mwseq_decode.sv
module mwseq_decode
  import mwseq_pkg::*;
(
  input  logic              busy,
  input  logic              second_half,
  input  logic              mode_wait,
  input  logic              line0_dflt,
  input  logic [PAIR_W-1:0] pair,
  input  logic              l0_t1,
  input  logic [1:0]        l0_code,
  output logic [N_LINES-1:0] gpl,
  output logic              oe4
);
  logic l0_hi;

  always_comb begin
    case (l0_code)
      L0_LOW:  l0_hi = 1'b0;
      L0_HIGH: l0_hi = 1'b1;
      default: l0_hi = line0_dflt;
    endcase
  end

  assign gpl[0] = busy & (second_half ? l0_hi : l0_t1);

  for (genvar k = 1; k < N_LINES; k++) begin : g_line
    if (k == 4) begin : g_shared
      assign gpl[k] = busy & ~mode_wait & (second_half ? pair[2*k-1] : pair[2*k-2]);
    end else begin : g_plain
      assign gpl[k] = busy & (second_half ? pair[2*k-1] : pair[2*k-2]);
    end
  end

  assign oe4 = ~mode_wait;
endmodule

// File: rtl/mwseq_top.sv
module mwseq_top
  import mwseq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_idx,
  input  logic               mode_wait,
  input  logic               line0_dflt,
  input  logic               read_op,
  input  logic               wait_in,
  output logic [N_LINES-1:0] gpl_out,
  output logic               gpl4_oe,
  output logic               sample_stb,
  output logic               busy,
  output logic               done
);
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  mw_word_t          word;
  logic              second_half, wait_s, frozen;

  assign wr_ready = ~busy;

  mwseq_table #(.ADDR_W(ADDR_W)) table_i (
    .clk(clk), .we(wr_valid & wr_ready), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_word)
  );

  mwseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(wait_in), .q(wait_s)
  );

  mwseq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .rd_word(rd_word), .mode_wait(mode_wait), .read_op(read_op),
    .wait_s(wait_s), .rd_addr(rd_addr), .word(word),
    .second_half(second_half), .busy(busy), .done(done),
    .frozen(frozen), .sample_stb(sample_stb)
  );

  mwseq_decode decode_i (
    .busy(busy), .second_half(second_half), .mode_wait(mode_wait),
    .line0_dflt(line0_dflt), .pair(word.pair), .l0_t1(word.l0_t1),
    .l0_code(word.l0_code), .gpl(gpl_out), .oe4(gpl4_oe)
  );
endmodule

// File: rtl/mwseq_chk.sv
module mwseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sample_stb,
  input logic       mode_wait,
  input logic       frozen,
  input logic [5:0] gpl_out
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> gpl_out == 6'b0);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_line4_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wait |-> !gpl_out[4]);

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(gpl_out));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
endmodule

bind mwseq_top mwseq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sample_stb(sample_stb), .mode_wait(mode_wait), .frozen(frozen),
  .gpl_out(gpl_out)
);

// File: tb/mwseq_tb.sv
module mwseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic [5:0]  start_idx = '0;
  logic        mode_wait = 1'b0;
  logic        line0_dflt = 1'b0;
  logic        read_op = 1'b0;
  logic        wait_in = 1'b0;
  logic [5:0]  gpl_out;
  logic        gpl4_oe, sample_stb, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mwseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .start_idx(start_idx),
    .mode_wait(mode_wait), .line0_dflt(line0_dflt), .read_op(read_op),
    .wait_in(wait_in), .gpl_out(gpl_out), .gpl4_oe(gpl4_oe),
    .sample_stb(sample_stb), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [15:0] w;
    logic        m;
    logic        d;
    logic [5:0]  f;
    logic [5:0]  s;
    logic        oe;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h9955, 1'b0, 1'b0, 6'h3F, 6'h00, 1'b1},
    '{16'h8EAA, 1'b0, 1'b0, 6'h00, 6'h3F, 1'b1},
    '{16'h8000, 1'b0, 1'b1, 6'h00, 6'h01, 1'b1},
    '{16'h8400, 1'b0, 1'b1, 6'h00, 6'h01, 1'b1},
    '{16'h8400, 1'b0, 1'b0, 6'h00, 6'h00, 1'b1},
    '{16'h80FF, 1'b1, 1'b0, 6'h0E, 6'h0E, 1'b0},
    '{16'h8189, 1'b0, 1'b0, 6'h22, 6'h14, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // returns at the negedge after the start edge (quarter phase 1)
  task automatic go(input logic [5:0] idx);
    @(negedge clk);
    start = 1'b1; start_idx = idx;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [5:0] s4, s5, s7;
    logic [4:0] stb;
    logic [5:0] g [8];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 strobe after reset", sample_stb, 0);
    chk("R1 lines after reset", gpl_out, 0);
    chk("R1 ready after reset", wr_ready, 1);

    // vector walk: R3 R4 R7 line levels per half
    for (int v = 0; v < NV; v++) begin
      mode_wait = VECS[v].m; line0_dflt = VECS[v].d;
      wr(6'd5, VECS[v].w);
      go(6'd5);
      chk("R2 busy in phase 1", busy, 1);
      chk("R3 phase 1 levels", gpl_out, VECS[v].f);
      chk("R7 shared line enable", gpl4_oe, VECS[v].oe);
      @(negedge clk); chk("R3 phase 2 levels", gpl_out, VECS[v].f);
      @(negedge clk); chk("R4 phase 3 levels", gpl_out, VECS[v].s);
      @(negedge clk); chk("R4 phase 4 levels", gpl_out, VECS[v].s);
      @(negedge clk);
      chk("R6 done after end word", done, 1);
      chk("R1 idle lines", gpl_out, 0);
      @(negedge clk);
      chk("R6 done single clock", done, 0);
    end
    mode_wait = 1'b0; line0_dflt = 1'b0;

    // R5 repeat counts
    wr(6'd50, 16'hE000);
    wr(6'd51, 16'hA000);
    go(6'd50); run_len(n); chk("R5 repeat 3 length", n, 16);
    go(6'd51); run_len(n); chk("R5 repeat 1 length", n, 8);

    // R6 sequential with wrap 63 -> 0
    wr(6'd63, 16'h0002);
    wr(6'd0, 16'h8004);
    go(6'd63);
    for (int i = 0; i < 8; i++) begin
      g[i] = gpl_out;
      @(negedge clk);
    end
    chk("R6 wrap end", busy, 0);
    chk("R6 first word phase 1", g[0], 6'h00);
    chk("R6 first word phase 3", g[2], 6'h02);
    chk("R6 wrapped word phase 1", g[4], 6'h04);
    chk("R6 wrapped word phase 3", g[6], 6'h00);

    // R12 start and write ignored while busy
    go(6'd50);
    n = 1;
    @(negedge clk); n++;
    chk("R12 ready low while busy", wr_ready, 0);
    start = 1'b1; start_idx = 6'd51;
    wr_valid = 1'b1; wr_addr = 6'd50; wr_data = 16'h8000;
    @(negedge clk); n++;
    start = 1'b0; wr_valid = 1'b0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    n--;
    chk("R12 run length with ignored start", n, 16);
    go(6'd50); run_len(n); chk("R12 write ignored while busy", n, 16);

    // R8 wait freeze
    mode_wait = 1'b1;
    wr(6'd30, 16'h6081);
    wr(6'd31, 16'h8080);
    go(6'd30);
    n = 1;
    @(negedge clk); n++;
    @(negedge clk); n++;
    wait_in = 1'b1;
    @(negedge clk); n++;
    @(negedge clk); n++; s4 = gpl_out;
    @(negedge clk); n++; s5 = gpl_out;
    @(negedge clk); n++;
    @(negedge clk); n++; s7 = gpl_out;
    wait_in = 1'b0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    n--;
    chk("R8 frozen run length", n, 25);
    chk("R8 outputs held 1", s5, s4);
    chk("R8 outputs held 2", s7, s4);

    // R9 wait ignored
    wr(6'd60, 16'h8000);
    wait_in = 1'b1;
    go(6'd60); run_len(n); chk("R9 wait not enabled", n, 4);
    mode_wait = 1'b0;
    wr(6'd61, 16'h8080);
    go(6'd61); run_len(n); chk("R9 wait in output mode", n, 4);
    wait_in = 1'b0;
    repeat (3) @(negedge clk);

    // R10 / R11 sample strobe
    mode_wait = 1'b1; read_op = 1'b1;
    wr(6'd40, 16'h8040);
    wr(6'd41, 16'h8000);
    go(6'd40);
    for (int i = 0; i < 5; i++) begin stb[i] = sample_stb; @(negedge clk); end
    chk("R10 strobe at phase 3", stb, 5'b00100);
    go(6'd41);
    for (int i = 0; i < 5; i++) begin stb[i] = sample_stb; @(negedge clk); end
    chk("R11 strobe at next phase 1", stb, 5'b10000);
    read_op = 1'b0;
    go(6'd40);
    for (int i = 0; i < 5; i++) begin stb[i] = sample_stb; @(negedge clk); end
    chk("R11 no strobe without read", stb, 5'b00000);
    mode_wait = 1'b0; read_op = 1'b1;
    go(6'd40);
    for (int i = 0; i < 5; i++) begin stb[i] = sample_stb; @(negedge clk); end
    chk("R11 no strobe in output mode", stb, 5'b00000);
    read_op = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule